// File: doc/BRIEF.md
# Register Redirection and Vector Tag Map

This block sits at instruction issue and reinterprets architectural register numbers. Sixteen configuration slots each bind one key register, in either the integer or the floating-point register file, to a starting physical register and a set of vector attributes: element width code, packed-SIMD flag and bank. The slots are expanded into one 32-entry view per register file, and three lookup ports (destination, first source, second source) read that view in the same cycle.

For each operand the block returns the register that element 0 lives in, whether the operand is a vector, its element width code, its packing flag and its bank bit. When none of the three operands is a vector it raises a flag so the operation can take the plain scalar path. Several keys may point at the same or overlapping physical registers; nothing forbids this.

Slots are written one at a time through a simple write strobe. A write becomes visible to lookups from the clock edge that stores it.

Top module: `regmap_top`

## Requirements
- R1: After reset every slot is cleared, and no lookup reports a vector, a nonzero element width or a set packed flag; every lookup returns its own register number.
- R2: A slot written with `cfg_we` high at a rising edge changes lookup results only after that edge; before it, the previous mapping is still returned.
- R3: The slot word is laid out as bit 15 = file select (0 integer, 1 floating point), bits 14:10 = key register, bits 9:5 = start register, bits 4:3 = element width code, bit 2 = vector flag, bit 1 = packed flag, bit 0 = bank. A slot with the vector flag set redirects lookups of its key in its own file to the start register; lookups in the other file are unaffected.
- R4: A slot that matches but has the vector flag clear leaves the register number unchanged while still reporting its element width code and packed flag.
- R5: A register with no matching slot is returned unchanged with vector, width, packed and bank outputs all zero.
- R6: When several slots carry the same file select and key, the one with the highest slot index decides the result.
- R7: A slot with bank = 1 is ignored: the lookup result is what it would be without that slot, and the bank output is therefore always 0.
- R8: `all_scalar` is 1 exactly when none of the three ports reports a vector.
- R9: The three ports are looked up independently in the same cycle, and two keys may redirect to the same start register.
- R10: The element width code is reported as stored: 0 = native width, 1 = half native, 2 = 8 bits, 3 = 16 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Slot write strobe |
| cfg_idx | input | 4 | Slot index to write |
| cfg_wdata | input | 16 | Slot word, layout in R3 |
| op_fp | input | 1 | Operation uses floating-point register view |
| op_reg | input | 3x5 | Architectural register per port (0 rd, 1 rs1, 2 rs2) |
| map_reg | output | 3x5 | Start register per port |
| map_vec | output | 3 | Vector flag per port |
| map_ew | output | 3x2 | Element width code per port |
| map_simd | output | 3 | Packed-SIMD flag per port |
| map_bank | output | 3 | Bank bit per port |
| all_scalar | output | 1 | No operand is a vector |

## Verification
The bench targets key collisions: a lower slot written after a higher one must not take over, and a design that scanned slots in the wrong order would return the stale start register. It places a bank-1 slot above a valid one; a design that let it win or clear the entry would lose the redirection. It checks that an integer slot leaves the floating-point view untouched and that a non-vector slot still reports width but not redirection, both of which a file-select or flag mix-up would break. Write timing is checked by sampling the old mapping in the cycle of the write, and random traffic over a small key set forces frequent overlaps.

// File: rtl/regmap_pkg.sv
package regmap_pkg;
  parameter int REG_W = 5;
  parameter int EW_W  = 2;

  typedef struct packed {
    logic             fp;
    logic [REG_W-1:0] key;
    logic [REG_W-1:0] base;
    logic [EW_W-1:0]  ew;
    logic             vec;
    logic             simd;
    logic             bank;
  } cfg_entry_t;

  typedef struct packed {
    logic             hit;
    logic [REG_W-1:0] base;
    logic [EW_W-1:0]  ew;
    logic             vec;
    logic             simd;
    logic             bank;
  } map_t;
endpackage

// File: rtl/regmap_cfg_store.sv
module regmap_cfg_store
  import regmap_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              we,
  input  logic [IDX_W-1:0]                  idx,
  input  cfg_entry_t                        wdata,
  output cfg_entry_t [NUM_ENTRIES-1:0]      entries
);
  cfg_entry_t [NUM_ENTRIES-1:0] store_q, store_d;

  always_comb begin
    store_d = store_q;
    if (we) store_d[idx] = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  store_q <= '0;
    else if (we) store_q <= store_d;
  end

  assign entries = store_q;
endmodule

// File: rtl/regmap_expand.sv
module regmap_expand
  import regmap_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  localparam int NUM_REGS = 1 << REG_W,
  localparam int VIEW_N   = 2 * NUM_REGS
) (
  input  cfg_entry_t [NUM_ENTRIES-1:0] entries,
  output map_t       [VIEW_N-1:0]      view
);
  for (genvar g = 0; g < VIEW_N; g++) begin : g_slot
    localparam logic [REG_W:0] SEL = REG_W'(g) | ((g >= NUM_REGS) ? (1 << REG_W) : 0);
    map_t m;
    always_comb begin
      m = '0;
      // ascending scan: a later (higher) slot overrides earlier ones
      for (int e = 0; e < NUM_ENTRIES; e++) begin
        if ({entries[e].fp, entries[e].key} == SEL && !entries[e].bank) begin
          m.hit  = 1'b1;
          m.base = entries[e].base;
          m.ew   = entries[e].ew;
          m.vec  = entries[e].vec;
          m.simd = entries[e].simd;
          m.bank = entries[e].bank;
        end
      end
    end
    assign view[g] = m;
  end
endmodule

// File: rtl/regmap_port.sv
module regmap_port
  import regmap_pkg::*;
#(
  localparam int NUM_REGS = 1 << REG_W,
  localparam int VIEW_N   = 2 * NUM_REGS
) (
  input  map_t [VIEW_N-1:0] view,
  input  logic              fp,
  input  logic [REG_W-1:0]  arch,
  output logic [REG_W-1:0]  phys,
  output logic              vec,
  output logic [EW_W-1:0]   ew,
  output logic              simd,
  output logic              bank
);
  map_t m;
  always_comb begin
    m    = view[{fp, arch}];
    vec  = m.hit & m.vec;
    phys = vec ? m.base : arch;
    ew   = m.hit ? m.ew : '0;
    simd = m.hit & m.simd;
    bank = m.hit & m.bank;
  end
endmodule

// File: rtl/regmap_top.sv
module regmap_top
  import regmap_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int NUM_PORTS   = 3,
  localparam int IDX_W  = $clog2(NUM_ENTRIES),
  localparam int CFG_W  = $bits(cfg_entry_t),
  localparam int VIEW_N = 2 * (1 << REG_W)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             cfg_we,
  input  logic [IDX_W-1:0]                 cfg_idx,
  input  logic [CFG_W-1:0]                 cfg_wdata,
  input  logic                             op_fp,
  input  logic [NUM_PORTS-1:0][REG_W-1:0]  op_reg,
  output logic [NUM_PORTS-1:0][REG_W-1:0]  map_reg,
  output logic [NUM_PORTS-1:0]             map_vec,
  output logic [NUM_PORTS-1:0][EW_W-1:0]   map_ew,
  output logic [NUM_PORTS-1:0]             map_simd,
  output logic [NUM_PORTS-1:0]             map_bank,
  output logic                             all_scalar
);
  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  cfg_entry_t [NUM_ENTRIES-1:0] entries;
  map_t       [VIEW_N-1:0]      view;

  regmap_cfg_store #(.NUM_ENTRIES(NUM_ENTRIES)) u_store (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .we      (cfg_we),
    .idx     (cfg_idx),
    .wdata   (cfg_entry_t'(cfg_wdata)),
    .entries (entries)
  );

  regmap_expand #(.NUM_ENTRIES(NUM_ENTRIES)) u_expand (
    .entries (entries),
    .view    (view)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    regmap_port u_port (
      .view (view),
      .fp   (op_fp),
      .arch (op_reg[p]),
      .phys (map_reg[p]),
      .vec  (map_vec[p]),
      .ew   (map_ew[p]),
      .simd (map_simd[p]),
      .bank (map_bank[p])
    );
  end

  assign all_scalar = ~|map_vec;
endmodule

// File: rtl/regmap_chk.sv
module regmap_chk
  import regmap_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int NUM_PORTS   = 3,
  localparam int IDX_W = $clog2(NUM_ENTRIES),
  localparam int CFG_W = $bits(cfg_entry_t)
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic                             cfg_we,
  input logic [IDX_W-1:0]                 cfg_idx,
  input logic [CFG_W-1:0]                 cfg_wdata,
  input logic                             op_fp,
  input logic [NUM_PORTS-1:0][REG_W-1:0]  op_reg,
  input logic [NUM_PORTS-1:0][REG_W-1:0]  map_reg,
  input logic [NUM_PORTS-1:0]             map_vec,
  input logic [NUM_PORTS-1:0][EW_W-1:0]   map_ew,
  input logic [NUM_PORTS-1:0]             map_simd,
  input logic [NUM_PORTS-1:0]             map_bank,
  input logic                             all_scalar
);
  logic wr_seen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      wr_seen_q <= 1'b0;
    else if (cfg_we) wr_seen_q <= 1'b1;
  end

  p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_seen_q |-> (map_vec == '0 && map_ew == '0 && map_simd == '0 && map_reg == op_reg));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!cfg_we) && $stable(op_fp) && $stable(op_reg)) |->
      ($stable(map_reg) && $stable(map_vec) && $stable(map_ew) && $stable(map_simd)));

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port_chk
    p_scalar_keeps_reg_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !map_vec[p] |-> map_reg[p] == op_reg[p]);
  end

  p_bank_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    map_bank == '0);

  p_all_scalar_r8: assert property (@(posedge clk) disable iff (!rst_n)
    all_scalar |-> map_reg == op_reg);
endmodule

bind regmap_top regmap_chk #(.NUM_ENTRIES(NUM_ENTRIES), .NUM_PORTS(NUM_PORTS)) u_chk (.*);

// File: tb/tb_regmap_top.sv
module tb_regmap_top;
  logic             clk = 1'b0;
  logic             rst_n;
  logic             cfg_we;
  logic [3:0]       cfg_idx;
  logic [15:0]      cfg_wdata;
  logic             op_fp;
  logic [2:0][4:0]  op_reg;
  logic [2:0][4:0]  map_reg;
  logic [2:0]       map_vec;
  logic [2:0][1:0]  map_ew;
  logic [2:0]       map_simd;
  logic [2:0]       map_bank;
  logic             all_scalar;

  int checks = 0;
  int failures = 0;
  logic [15:0] mdl [16];

  always #4 clk = ~clk;

  regmap_top dut (.*);

  function automatic logic [15:0] mk(logic fp, logic [4:0] key, logic [4:0] base,
                                     logic [1:0] ew, logic vec, logic simd, logic bank);
    return {fp, key, base, ew, vec, simd, bank};
  endfunction

  // expected {reg, vec, ew, simd, bank} for one lookup
  function automatic logic [9:0] expect_port(logic fp, logic [4:0] r);
    logic [9:0] res;
    res = {r, 5'b0};
    for (int e = 0; e < 16; e++) begin
      if (mdl[e][15] == fp && mdl[e][14:10] == r && !mdl[e][0])
        res = {mdl[e][2] ? mdl[e][9:5] : r, mdl[e][2], mdl[e][4:3], mdl[e][1], 1'b0};
    end
    return res;
  endfunction

  task automatic check(logic [31:0] act, logic [31:0] exp, string req);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [9:0] got(int p);
    return {map_reg[p], map_vec[p], map_ew[p], map_simd[p], map_bank[p]};
  endfunction

  task automatic check_all(string req);
    logic sc;
    sc = 1'b1;
    for (int p = 0; p < 3; p++) begin
      logic [9:0] e;
      e = expect_port(op_fp, op_reg[p]);
      check({22'b0, got(p)}, {22'b0, e}, req);
      if (e[4]) sc = 1'b0;
    end
    check({31'b0, all_scalar}, {31'b0, sc}, "R8");
  endtask

  task automatic wr(int idx, logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 4'(idx); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    mdl[idx] = d;
  endtask

  task automatic look(logic fp, logic [4:0] a, logic [4:0] b, logic [4:0] c, string req);
    @(negedge clk);
    op_fp = fp; op_reg[0] = a; op_reg[1] = b; op_reg[2] = c;
    #2;
    check_all(req);
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int e = 0; e < 16; e++) mdl[e] = '0;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_idx = '0; cfg_wdata = '0;
    op_fp = 1'b0; op_reg = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 / R5: cleared state, pass-through
    look(1'b0, 5'd0, 5'd3, 5'd31, "R1");
    look(1'b1, 5'd7, 5'd12, 5'd0, "R5");

    // R2: old mapping before edge, new after
    @(negedge clk);
    op_fp = 1'b0; op_reg[0] = 5'd3; op_reg[1] = 5'd1; op_reg[2] = 5'd2;
    cfg_we = 1'b1; cfg_idx = 4'd0; cfg_wdata = mk(1'b0, 5'd3, 5'd10, 2'd2, 1'b1, 1'b1, 1'b0);
    #2;
    check({22'b0, got(0)}, {22'b0, 5'd3, 5'b0}, "R2 before edge");
    @(negedge clk);
    cfg_we = 1'b0;
    mdl[0] = cfg_wdata;
    #2;
    check({22'b0, got(0)}, {22'b0, 5'd10, 1'b1, 2'd2, 1'b1, 1'b0}, "R2 after edge");

    // R3 / R10: redirection in own file, other file untouched
    look(1'b0, 5'd3, 5'd3, 5'd4, "R3");
    look(1'b1, 5'd3, 5'd3, 5'd3, "R3 other file");

    // R6: highest slot wins
    wr(5, mk(1'b0, 5'd3, 5'd20, 2'd3, 1'b1, 1'b0, 1'b0));
    wr(2, mk(1'b0, 5'd3, 5'd25, 2'd1, 1'b1, 1'b0, 1'b0));
    look(1'b0, 5'd3, 5'd0, 5'd0, "R6");
    check({27'b0, map_reg[0]}, 32'd20, "R6 direct");

    // R7: bank=1 ignored
    wr(9, mk(1'b0, 5'd3, 5'd30, 2'd0, 1'b1, 1'b1, 1'b1));
    look(1'b0, 5'd3, 5'd30, 5'd3, "R7");
    check({27'b0, map_reg[0]}, 32'd20, "R7 direct");

    // R4 / R10: non-vector slot
    wr(6, mk(1'b1, 5'd7, 5'd15, 2'd1, 1'b0, 1'b1, 1'b0));
    look(1'b1, 5'd7, 5'd8, 5'd7, "R4");
    check({30'b0, map_ew[0]}, 32'd1, "R10 direct");

    // R9: overlap, three independent ports
    wr(7, mk(1'b0, 5'd4, 5'd20, 2'd0, 1'b1, 1'b0, 1'b0));
    look(1'b0, 5'd3, 5'd4, 5'd5, "R9");
    check({17'b0, map_reg}, {17'b0, 5'd5, 5'd20, 5'd20}, "R9 direct");

    // random traffic over a small key set
    void'($urandom(32'h5EED1234));
    for (int it = 0; it < 400; it++) begin
      if ($urandom % 3 == 0) begin
        wr(int'($urandom % 16),
           mk(1'($urandom), 5'($urandom % 8), 5'($urandom), 2'($urandom), 1'($urandom),
              1'($urandom), ($urandom % 4) == 0));
      end else begin
        look(1'($urandom), 5'($urandom % 10), 5'($urandom % 10), 5'($urandom % 10), "R6 random");
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule